// File: doc/BRIEF.md
# USB Host Interrupt Enable Set/Clear Controller

This block holds the interrupt enable mask of a USB host controller and produces its single interrupt request. Software never writes the mask directly. One register offset sets mask bits wherever the written word has ones. A second offset clears mask bits wherever the written word has ones. Reading either offset returns the current mask.

Seven event sources each deliver a one-cycle pulse. Each pulse sets a sticky status bit, and software clears that bit by writing a one to it at the status offset. The interrupt output is raised when the global master bit of the mask is set and at least one status bit has its enable bit set. The bus side is a plain strobe interface with a combinational read path. Registers update on the rising clock edge.

Top module: `usb_irq_mask_ctrl`

## Requirements
- R1: After an asynchronous reset the mask and status are all zero, irq_o is low, and all three offsets read 0.
- R2: A write at offset 0x10 sets every implemented mask bit where wdata_i has a 1. Mask bits where wdata_i has a 0 keep their value.
- R3: A write at offset 0x14 clears every mask bit where wdata_i has a 1. Mask bits where wdata_i has a 0 keep their value.
- R4: A read at offset 0x10 and a read at offset 0x14 return the same current mask value.
- R5: The implemented mask bits are 31 (master), 30, 6, 5, 3, 2, 1 and 0. Bit 4 and bits 29:7 always read 0, and writing them at either offset has no effect.
- R6: Event inputs map to status bits as follows: evt_i[0] to bit 0 (scheduling overrun), evt_i[1] to bit 1 (writeback done head), evt_i[2] to bit 2 (start of frame), evt_i[3] to bit 3 (resume detected), evt_i[4] to bit 5 (frame number overflow), evt_i[5] to bit 6 (root hub status change), and evt_i[6] to bit 30 (ownership change). A status bit stays set until software clears it.
- R7: Status reads at offset 0x0C. A write there clears each status bit where wdata_i has a 1. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: irq_o is high exactly when mask bit 31 is set and some status bit has its mask bit set. Writing bit 31 at offset 0x14 forces irq_o low.
- R9: When a mask write and an event arrive in the same cycle, both take effect, and irq_o reflects the combined state after that clock edge.
- R10: rdata_o is 0 whenever rd_en_i is low, and 0 for any address other than 0x0C, 0x10 and 0x14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| evt_i | input | 7 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, offsets 0x0C, 0x10 and 0x14, and the fixed seven-source bit map. With these values every implemented bit, the unimplemented bit 4 and the reserved range can all be reached by random full-word writes. An unused address is also in reach to confirm that it is ignored. Random events are mixed with set, clear and status writes, so same-cycle collisions occur often. Directed cases pin down event-beats-clear, master disable, and a write landing together with an event.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SRC_NUM    = 7;
  localparam int unsigned MASTER_BIT = 31;

  // status/mask bit position of each event source
  localparam int unsigned SRC_BIT [SRC_NUM] = '{0, 1, 2, 3, 5, 6, 30};

  function automatic logic [REG_W-1:0] src_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_NUM; i++) m[SRC_BIT[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] SRC_MASK  = src_bits();
  localparam logic [REG_W-1:0] MASK_IMPL = SRC_MASK | (REG_W'(1) << MASTER_BIT);
endpackage

// File: rtl/usb_irq_addr_dec.sv
module usb_irq_addr_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_ST  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_EN  = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_DIS = 8'h14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              wr_set_o,
  output logic              wr_clr_o,
  output logic              wr_st_o,
  output logic              rd_mask_o,
  output logic              rd_st_o
);
  logic hit_en, hit_dis, hit_st;

  always_comb begin
    hit_en    = (addr_i == OFF_EN);
    hit_dis   = (addr_i == OFF_DIS);
    hit_st    = (addr_i == OFF_ST);
    wr_set_o  = wr_en_i & hit_en;
    wr_clr_o  = wr_en_i & hit_dis;
    wr_st_o   = wr_en_i & hit_st;
    rd_mask_o = rd_en_i & (hit_en | hit_dis);
    rd_st_o   = rd_en_i & hit_st;
  end
endmodule

// File: rtl/usb_irq_mask_reg.sv
module usb_irq_mask_reg
  import usb_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mask_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (MASK_IMPL[b]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   q <= 1'b0;
        else if (set_i && wdata_i[b])  q <= 1'b1;
        else if (clr_i && wdata_i[b])  q <= 1'b0;
      end
      assign mask_o[b] = q;
    end else begin : g_rsv
      assign mask_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_status_reg.sv
module usb_irq_status_reg
  import usb_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [SRC_NUM-1:0] evt_i,
  output logic [REG_W-1:0]   stat_o
);
  logic [REG_W-1:0] evt_pos;

  always_comb begin
    evt_pos = '0;
    for (int i = 0; i < SRC_NUM; i++) evt_pos[SRC_BIT[i]] = evt_i[i];
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (SRC_MASK[b]) begin : g_src
      logic q;
      // a new event wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  q <= 1'b0;
        else if (evt_pos[b])          q <= 1'b1;
        else if (clr_i && wdata_i[b]) q <= 1'b0;
      end
      assign stat_o[b] = q;
    end else begin : g_none
      assign stat_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_gen.sv
module usb_irq_gen
  import usb_irq_pkg::*;
(
  input  logic [REG_W-1:0] mask_i,
  input  logic [REG_W-1:0] stat_i,
  output logic             irq_o
);
  logic [REG_W-1:0] pend;

  always_comb begin
    pend  = stat_i & mask_i & SRC_MASK;
    irq_o = mask_i[MASTER_BIT] & (|pend);
  end
endmodule

// File: rtl/usb_irq_mask_ctrl.sv
module usb_irq_mask_ctrl
  import usb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_ST  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_EN  = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_DIS = 8'h14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [SRC_NUM-1:0] evt_i,
  output logic               irq_o
);
  logic wr_set, wr_clr, wr_st, rd_mask, rd_st;
  logic [REG_W-1:0] mask_q, stat_q;

  usb_irq_addr_dec #(
    .ADDR_W(ADDR_W), .OFF_ST(OFF_ST), .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS)
  ) u_dec (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wr_set_o(wr_set), .wr_clr_o(wr_clr), .wr_st_o(wr_st),
    .rd_mask_o(rd_mask), .rd_st_o(rd_st)
  );

  usb_irq_mask_reg u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wr_set), .clr_i(wr_clr),
    .wdata_i(wdata_i), .mask_o(mask_q)
  );

  usb_irq_status_reg u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(wr_st), .wdata_i(wdata_i),
    .evt_i(evt_i), .stat_o(stat_q)
  );

  usb_irq_gen u_gen (.mask_i(mask_q), .stat_i(stat_q), .irq_o(irq_o));

  always_comb begin
    rdata_o = '0;
    if (rd_mask)    rdata_o = mask_q;
    else if (rd_st) rdata_o = stat_q;
  end
endmodule

// File: rtl/usb_irq_mask_ctrl_chk.sv
module usb_irq_mask_ctrl_chk
  import usb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_ST  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_EN  = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_DIS = 8'h14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  stat_q
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EN) |=>
      ((mask_q & $past(wdata_i) & MASK_IMPL) == ($past(wdata_i) & MASK_IMPL)));

  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIS) |=> ((mask_q & $past(wdata_i)) == '0));

  p_rsv_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> ((rdata_o & ~MASK_IMPL) == '0));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFF_ST) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_master_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q[MASTER_BIT] |-> !irq_o);

  p_no_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_q) == '0) |-> !irq_o);

  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

bind usb_irq_mask_ctrl usb_irq_mask_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFF_ST(OFF_ST), .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/usb_irq_mask_ctrl_tb.sv
module usb_irq_mask_ctrl_tb;
  localparam logic [7:0]  A_ST  = 8'h0C;
  localparam logic [7:0]  A_EN  = 8'h10;
  localparam logic [7:0]  A_DIS = 8'h14;
  localparam logic [7:0]  A_BAD = 8'h18;
  localparam logic [31:0] M_OK  = 32'hC000_006F;
  localparam logic [31:0] S_OK  = 32'h4000_006F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  evt_i = '0;
  logic        irq_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_mask = '0, m_stat = '0;

  always #5 clk_i = ~clk_i;

  usb_irq_mask_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] ev_map(logic [6:0] e);
    return {1'b0, e[6], 23'd0, e[5], e[4], 1'b0, e[3], e[2], e[1], e[0]};
  endfunction

  function automatic logic exp_irq(logic [31:0] m, logic [31:0] s);
    return m[31] && ((m & s & S_OK) != 0);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // one clock with optional write and events; caller sits at negedge
  task automatic step(logic wr, logic [7:0] a, logic [31:0] wd, logic [6:0] ev);
    wr_en_i = wr; addr_i = a; wdata_i = wd; evt_i = ev;
    @(posedge clk_i);
    if (wr && a == A_EN)  m_mask = m_mask | (wd & M_OK);
    if (wr && a == A_DIS) m_mask = m_mask & ~(wd & M_OK);
    if (wr && a == A_ST)  m_stat = m_stat & ~(wd & S_OK);
    m_stat = m_stat | ev_map(ev);
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
    chk({31'd0, irq_o}, {31'd0, exp_irq(m_mask, m_stat)}, "R8/R9 irq");
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    rd_en_i = 1'b1; addr_i = a;
    #1 chk(rdata_o, exp, tag);
    rd_en_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq");
    rd(A_EN, 32'd0, "R1 en");
    rd(A_ST, 32'd0, "R1 st");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 / R5: full-ones write only lands on implemented bits
    step(1'b1, A_EN, 32'hFFFF_FFFF, '0);
    rd(A_EN, M_OK, "R2 R5 set all");
    rd(A_DIS, M_OK, "R4 mirror");
    // R3 clear with zeros elsewhere leaves others
    step(1'b1, A_DIS, 32'h0000_0005, '0);
    rd(A_EN, M_OK & ~32'h5, "R3 partial clear");
    // R5 bit 4 ignored at both offsets
    step(1'b1, A_EN, 32'h0000_0010, '0);
    rd(A_EN, M_OK & ~32'h5, "R5 bit4 set");
    step(1'b1, A_DIS, 32'h3FFF_FF90, '0);
    rd(A_DIS, M_OK & ~32'h5, "R5 reserved clear");
    // R10 idle and unmapped reads
    rd(A_BAD, 32'd0, "R10 unmapped");
    step(1'b1, A_BAD, 32'hFFFF_FFFF, '0);
    rd(A_EN, M_OK & ~32'h5, "R10 unmapped write");

    // R6 mapping, each source
    for (int i = 0; i < 7; i++) begin
      step(1'b0, A_EN, '0, 7'(1 << i));
      rd(A_ST, m_stat, "R6 map");
    end
    // R7 event beats clear on same bit
    step(1'b1, A_ST, 32'hFFFF_FFFF, 7'h40);
    rd(A_ST, 32'h4000_0000, "R7 evt wins");
    step(1'b1, A_ST, 32'h4000_0000, '0);
    rd(A_ST, 32'd0, "R7 w1c");
    // R8 master off kills irq
    step(1'b0, A_EN, '0, 7'h02);
    chk({31'd0, irq_o}, 32'd1, "R8 irq on");
    step(1'b1, A_DIS, 32'h8000_0000, '0);
    chk({31'd0, irq_o}, 32'd0, "R8 master off");
    // R9 write and event same cycle
    step(1'b1, A_EN, 32'h8000_0000, 7'h01);
    chk({31'd0, irq_o}, 32'd1, "R9 combined");
    rd(A_ST, 32'h3, "R9 status");

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [7:0]  a;
      logic [31:0] wd;
      logic [6:0]  ev;
      int op;
      op = $urandom % 5;
      a  = (op == 0) ? A_EN : (op == 1) ? A_DIS : (op == 2) ? A_ST : A_BAD;
      wd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      ev = 7'($urandom & $urandom & $urandom);
      step(op != 4, a, wd, ev);
      case ($urandom % 3)
        0: rd(A_EN, m_mask, "R2 R3 rand mask");
        1: rd(A_DIS, m_mask, "R4 rand mask");
        default: rd(A_ST, m_stat, "R6 R7 rand stat");
      endcase
    end
    finish_run();
  end
endmodule